// File: doc/BRIEF.md
# Zero-Substitution Line Decoder with Code-Violation Flag

This block sits behind a clock and data recovery stage and takes recovered line symbols on two rails: one rail marks positive pulses and the other marks negative pulses, one symbol per clock. A format input selects one of two outputs. In dual-rail output mode the two rails are registered once and passed on, and nothing is checked. In single-bit mode the block removes zero-substitution codes and drives one NRZ data bit, together with a code-violation flag that lines up with the bit it describes.

A code input selects the three-zero code (B3ZS, used at the DS3 and STS-1 rates) or the four-zero code (HDB3). A pulse is a bipolar violation when it has the same polarity as the previous pulse. The decoder recognises the two substitution shapes of the selected code and rewrites each one to zeros. It flags only the violations that no legal substitution can produce. Both mode inputs are expected to stay static while traffic flows, and a change is followed by a reset.

Top module: `zsub_line_decoder`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0, whatever the inputs do.
- R2: With `fmt_bipolar_i` = 1, `rail_pos_o` and `rail_neg_o` show the `rail_pos_i` and `rail_neg_i` values of the previous clock interval.
- R3: With `fmt_bipolar_i` = 1, `nrz_o` and `cv_o` stay 0 for any input pattern, including back-to-back same-polarity pulses and long runs of empty intervals.
- R4: With `fmt_bipolar_i` = 0, `rail_pos_o` and `rail_neg_o` stay 0. A symbol applied in interval k reaches `nrz_o` and `cv_o` in interval k+L+1, where L is 3 when `code_hdb3_i` = 0 and 4 when `code_hdb3_i` = 1. A pulse on one rail decodes to 1 unless it belongs to a substitution, and an empty interval decodes to 0. The first pulse after reset counts as a valid pulse.
- R5: With `code_hdb3_i` = 0, two empty intervals followed by a violation (00V), and a valid pulse, one empty interval and a violation (B0V), each decode to three 0 bits with no flag of their own.
- R6: With `code_hdb3_i` = 1, the patterns 000V and B00V each decode to four 0 bits. A B0V pattern is not a substitution in this code and decodes to 1, 0, 1.
- R7: A violation that directly follows a valid pulse, with no empty interval between them, raises `cv_o` on its own bit, and that bit decodes to 1.
- R8: A violation with the same polarity as the previous violation raises `cv_o` on its own bit. If it completes a substitution shape, the group still decodes to zeros.
- R9: Pulses on both rails in the same interval decode to 1 with `cv_o` raised. This symbol ends any run of empty intervals and cannot act as the leading pulse of a substitution.
- R10: Within a run of empty intervals, each interval after the L-th raises `cv_o` on its own 0 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one line symbol per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_bipolar_i | input | 1 | 1: dual-rail pass-through; 0: decoded single-bit output |
| code_hdb3_i | input | 1 | 0: three-zero code; 1: four-zero code |
| rail_pos_i | input | 1 | Positive pulse present in this interval |
| rail_neg_i | input | 1 | Negative pulse present in this interval |
| rail_pos_o | output | 1 | Registered positive rail (pass-through mode only) |
| rail_neg_o | output | 1 | Registered negative rail (pass-through mode only) |
| nrz_o | output | 1 | Decoded data bit (decode mode only) |
| cv_o | output | 1 | Code violation for the bit on `nrz_o` |

## Verification
The hardest case to reach from the ports is a violation that both completes a legal substitution shape and repeats the polarity of the previous violation. The group must be zeroed and flagged at once, and the leading valid pulse must be rewritten after it has already entered the pipeline. The stimulus table reaches this by placing a violation of known polarity first, then a pulse stream whose pulse polarity history puts the next substitution on the same polarity. This is done in both codes, and for HDB3 the leading pulse is a valid B that must turn to 0. The same table also places a B0V shape in the four-zero code, where it must not be taken as a substitution.

// File: rtl/zsd_pkg.sv
package zsd_pkg;

   // one recovered line symbol: a mark on either rail
   typedef struct packed {
      logic pos;
      logic neg;
   } rail_pair_t;

   // classification of an incoming symbol against the running line history
   typedef enum logic [1:0] {
      SYM_NONE = 2'd0,   // empty interval
      SYM_MARK = 2'd1,   // pulse obeying alternation
      SYM_VIOL = 2'd2,   // pulse repeating the previous polarity
      SYM_DUAL = 2'd3    // both rails at once
   } sym_kind_e;

endpackage

// File: rtl/zsd_classify.sv
module zsd_classify
   import zsd_pkg::*;
#(
   parameter int LW   = 3,
   parameter int ZCAP = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_i,
   input  logic [LW-1:0]   len_i,
   input  rail_pair_t      sym_i,
   output logic            bit_o,
   output logic            flag_o,
   output logic            clr_o
);

   localparam logic [LW-1:0] ONE_V  = LW'(1);
   localparam logic [LW-1:0] TWO_V  = LW'(2);
   localparam logic [LW-1:0] CAP_V  = LW'(ZCAP);

   // running history of the line
   logic            seen_q;      // any pulse since reset
   logic            last_neg_q;  // polarity of the most recent pulse
   logic            last_b_q;    // most recent pulse was a valid mark
   logic            prev_b_q;    // the interval just before was a valid mark
   logic            v_seen_q;    // any violation since reset
   logic            v_neg_q;     // polarity of the most recent violation
   logic [LW-1:0]   zrun_q;      // empty intervals since the last pulse

   sym_kind_e kind;
   logic      fill_all, fill_lead, sub_hit, adj_viol, rep_pol, long_gap;

   always_comb begin
      kind = SYM_NONE;
      if (sym_i.pos && sym_i.neg) begin
         kind = SYM_DUAL;
      end else if (sym_i.pos || sym_i.neg) begin
         kind = (seen_q && (sym_i.neg == last_neg_q)) ? SYM_VIOL : SYM_MARK;
      end
      // substitution shapes: zeros then V, or B, zeros, V
      fill_all  = (zrun_q == (len_i - ONE_V));
      fill_lead = (zrun_q == (len_i - TWO_V)) && last_b_q;
      sub_hit   = (kind == SYM_VIOL) && (fill_all || fill_lead);
      adj_viol  = (kind == SYM_VIOL) && (zrun_q == '0) && prev_b_q;
      rep_pol   = (kind == SYM_VIOL) && v_seen_q && (sym_i.neg == v_neg_q);
      long_gap  = (kind == SYM_NONE) && (zrun_q >= len_i);

      bit_o  = en_i && (kind != SYM_NONE);
      flag_o = en_i && ((kind == SYM_DUAL) || adj_viol || rep_pol || long_gap);
      clr_o  = en_i && sub_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q     <= 1'b0;
         last_neg_q <= 1'b0;
         last_b_q   <= 1'b0;
         prev_b_q   <= 1'b0;
         v_seen_q   <= 1'b0;
         v_neg_q    <= 1'b0;
         zrun_q     <= '0;
      end else if (!en_i) begin
         seen_q     <= 1'b0;
         last_neg_q <= 1'b0;
         last_b_q   <= 1'b0;
         prev_b_q   <= 1'b0;
         v_seen_q   <= 1'b0;
         v_neg_q    <= 1'b0;
         zrun_q     <= '0;
      end else begin
         unique case (kind)
            SYM_NONE: begin
               zrun_q   <= (zrun_q == CAP_V) ? zrun_q : zrun_q + ONE_V;
               prev_b_q <= 1'b0;
            end
            SYM_DUAL: begin
               zrun_q   <= '0;
               prev_b_q <= 1'b0;
               last_b_q <= 1'b0;
            end
            SYM_MARK: begin
               seen_q     <= 1'b1;
               last_neg_q <= sym_i.neg;
               last_b_q   <= 1'b1;
               prev_b_q   <= 1'b1;
               zrun_q     <= '0;
            end
            SYM_VIOL: begin
               last_b_q <= 1'b0;
               prev_b_q <= 1'b0;
               v_seen_q <= 1'b1;
               v_neg_q  <= sym_i.neg;
               zrun_q   <= '0;
            end
            default: begin
               zrun_q <= '0;
            end
         endcase
      end
   end

   // R10: a pulse of any kind ends the empty run that the gap check counts
   p_gap_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(sym_i.pos || sym_i.neg) |-> (zrun_q == '0));

endmodule

// File: rtl/zsd_align_pipe.sv
module zsd_align_pipe #(
   parameter int DEPTH = 4,
   parameter int LW    = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LW-1:0]   len_i,
   input  logic            bit_i,
   input  logic            flag_i,
   input  logic            clr_i,
   output logic            bit_o,
   output logic            flag_o
);

   logic [DEPTH-1:0] data_q;
   logic [DEPTH-1:0] flag_q;
   logic [DEPTH-1:0] grp_mask;

   // stages that hold one substitution group once the current symbol lands
   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         grp_mask[j] = (j < int'(len_i));
      end
   end

   for (genvar j = 0; j < DEPTH; j++) begin : g_stage
      if (j == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q[0] <= 1'b0;
               flag_q[0] <= 1'b0;
            end else begin
               data_q[0] <= bit_i && !clr_i;
               flag_q[0] <= flag_i;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q[j] <= 1'b0;
               flag_q[j] <= 1'b0;
            end else begin
               data_q[j] <= data_q[j-1] && !(clr_i && grp_mask[j]);
               flag_q[j] <= flag_q[j-1];
            end
         end
      end
   end

   // output tap sits at the last stage of the active group length
   always_comb begin
      bit_o  = 1'b0;
      flag_o = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
         if (j == int'(len_i) - 1) begin
            bit_o  = data_q[j];
            flag_o = flag_q[j];
         end
      end
   end

   // R5/R6: a recognised substitution leaves its whole group at zero
   p_group_zeroed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(clr_i) |-> ((data_q & $past(grp_mask)) == '0));

endmodule

// File: rtl/zsd_bypass.sv
module zsd_bypass
   import zsd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  rail_pair_t rails_i,
   output rail_pair_t rails_o
);

   rail_pair_t rails_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rails_q <= '0;
      end else begin
         rails_q <= en_i ? rails_i : '0;
      end
   end

   assign rails_o = rails_q;

   // R2: pass-through mode echoes the rails one interval later
   p_bypass_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(en_i) |-> (rails_o == $past(rails_i)));

endmodule

// File: rtl/zsub_line_decoder.sv
module zsub_line_decoder
   import zsd_pkg::*;
#(
   parameter int B3ZS_LEN = 3,
   parameter int HDB3_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fmt_bipolar_i,
   input  logic code_hdb3_i,
   input  logic rail_pos_i,
   input  logic rail_neg_i,
   output logic rail_pos_o,
   output logic rail_neg_o,
   output logic nrz_o,
   output logic cv_o
);

   localparam int DEPTH = HDB3_LEN;
   localparam int ZCAP  = HDB3_LEN + 1;
   localparam int LW    = $clog2(ZCAP + 1);

   // elaboration-time parameter checks
   if (B3ZS_LEN < 3) begin : g_bad_short
      $error("zsub_line_decoder: B3ZS_LEN must be at least 3");
   end
   if (HDB3_LEN < B3ZS_LEN) begin : g_bad_order
      $error("zsub_line_decoder: HDB3_LEN must not be below B3ZS_LEN");
   end

   rail_pair_t      sym_in;
   rail_pair_t      sym_out;
   logic [LW-1:0]   code_len;
   logic            dec_en;
   logic            cls_bit, cls_flag, cls_clr;
   logic            tap_bit, tap_flag;
   logic            nrz_q, cv_q;

   assign sym_in   = '{pos: rail_pos_i, neg: rail_neg_i};
   assign code_len = code_hdb3_i ? LW'(HDB3_LEN) : LW'(B3ZS_LEN);
   assign dec_en   = !fmt_bipolar_i;

   zsd_bypass u_bypass (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (fmt_bipolar_i),
      .rails_i (sym_in),
      .rails_o (sym_out)
   );

   zsd_classify #(.LW(LW), .ZCAP(ZCAP)) u_class (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (dec_en),
      .len_i   (code_len),
      .sym_i   (sym_in),
      .bit_o   (cls_bit),
      .flag_o  (cls_flag),
      .clr_o   (cls_clr)
   );

   zsd_align_pipe #(.DEPTH(DEPTH), .LW(LW)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .len_i   (code_len),
      .bit_i   (cls_bit),
      .flag_i  (cls_flag),
      .clr_i   (cls_clr),
      .bit_o   (tap_bit),
      .flag_o  (tap_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nrz_q <= 1'b0;
         cv_q  <= 1'b0;
      end else begin
         nrz_q <= dec_en && tap_bit;
         cv_q  <= dec_en && tap_flag;
      end
   end

   assign rail_pos_o = sym_out.pos;
   assign rail_neg_o = sym_out.neg;
   assign nrz_o      = nrz_q;
   assign cv_o       = cv_q;

   // R3: pass-through mode never reports decoded data or violations
   p_bip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fmt_bipolar_i) |-> (!nrz_o && !cv_o));

   // R4: decode mode leaves the rail outputs idle
   p_nrz_rails_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!fmt_bipolar_i) |-> (!rail_pos_o && !rail_neg_o));

   // R9: a dual-rail symbol emerges as a flagged 1 after the three-zero latency
   p_dual_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rail_pos_i && rail_neg_i && !fmt_bipolar_i && !code_hdb3_i, 4)
      && $past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) && $past(rst_n, 4)
      && $past(!code_hdb3_i, 1) && $past(!code_hdb3_i, 2) && $past(!code_hdb3_i, 3)
      && $past(!fmt_bipolar_i)
      |-> (nrz_o && cv_o));

endmodule

// File: tb/sim_zsub_line_decoder.sv
module sim_zsub_line_decoder;

   localparam int LEN3 = 3;
   localparam int LEN4 = 4;
   localparam int NV   = 62;

   // vector fields: {code_hdb3, pos, neg, expected nrz, expected cv}
   localparam logic [4:0] VEC [NV] = '{
      // three-zero code
      5'b0_10_10, 5'b0_01_10, 5'b0_00_00, 5'b0_00_00, 5'b0_01_00,   // 00V            R5
      5'b0_10_00, 5'b0_00_00, 5'b0_10_00,                           // B0V            R5
      5'b0_01_10, 5'b0_01_11,                                       // B then V       R7
      5'b0_10_10, 5'b0_00_00, 5'b0_00_00, 5'b0_10_00,               // 00V after B    R5
      5'b0_00_00, 5'b0_00_00, 5'b0_10_01,                           // repeat pol     R8
      5'b0_11_11,                                                   // dual rail      R9
      5'b0_01_10, 5'b0_00_00, 5'b0_00_00, 5'b0_00_00, 5'b0_00_01,   // long gap       R10
      5'b0_10_10, 5'b0_01_10,
      // four-zero code
      5'b1_01_10, 5'b1_10_10, 5'b1_00_00, 5'b1_00_00, 5'b1_00_00,
      5'b1_10_00,                                                   // 000V           R6
      5'b1_01_00, 5'b1_00_00, 5'b1_00_00, 5'b1_01_00,               // B00V           R6
      5'b1_10_10, 5'b1_01_00, 5'b1_00_00, 5'b1_00_00, 5'b1_01_01,   // B00V repeat    R8
      5'b1_10_10, 5'b1_10_11,                                       // B then V       R7
      5'b1_00_00, 5'b1_00_00, 5'b1_00_00, 5'b1_00_00, 5'b1_00_01,   // long gap       R10
      5'b1_01_10, 5'b1_00_00, 5'b1_00_00, 5'b1_10_10,
      5'b1_00_00, 5'b1_00_00, 5'b1_00_00, 5'b1_10_01,               // 000V repeat    R8
      5'b1_01_00, 5'b1_00_00, 5'b1_00_00, 5'b1_01_00,               // B00V           R6
      5'b1_10_10, 5'b1_00_00, 5'b1_10_10                            // B0V kept       R6
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fmt_bipolar = 1'b0;
   logic code_hdb3 = 1'b0;
   logic rp = 1'b0;
   logic rn = 1'b0;
   logic rail_pos_o, rail_neg_o, nrz_o, cv_o;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   zsub_line_decoder u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .fmt_bipolar_i (fmt_bipolar),
      .code_hdb3_i   (code_hdb3),
      .rail_pos_i    (rp),
      .rail_neg_i    (rn),
      .rail_pos_o    (rail_pos_o),
      .rail_neg_o    (rail_neg_o),
      .nrz_o         (nrz_o),
      .cv_o          (cv_o)
   );

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic bip, input logic hd);
      @(negedge clk);
      rst_n       = 1'b0;
      fmt_bipolar = bip;
      code_hdb3   = hd;
      rp          = 1'b1;
      rn          = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 outputs in reset", {rail_pos_o, rail_neg_o, nrz_o, cv_o}, 4'b0000);
      rp    = 1'b0;
      rn    = 1'b0;
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int s0;
      logic [1:0] prev;
      logic [1:0] bip_seq [12];

      // table walk, one segment per code, reset at each code change
      s0 = 0;
      while (s0 < NV) begin
         int   s1;
         int   lat;
         logic hd;
         s1 = s0;
         while (s1 + 1 < NV && VEC[s1+1][4] == VEC[s0][4]) s1++;
         hd  = VEC[s0][4];
         lat = hd ? LEN4 + 1 : LEN3 + 1;
         do_reset(1'b0, hd);
         for (int j = s0; j <= s1 + lat; j++) begin
            @(negedge clk);
            if (j - lat >= s0) begin
               check("R4 R5 R6 nrz", {3'b000, nrz_o}, {3'b000, VEC[j-lat][1]});
               check("R7 R8 R9 R10 cv", {3'b000, cv_o}, {3'b000, VEC[j-lat][0]});
            end
            check("R4 rails idle", {2'b00, rail_pos_o, rail_neg_o}, 4'b0000);
            if (j <= s1) begin
               {rp, rn} = VEC[j][3:2];
            end else begin
               {rp, rn} = 2'b00;
            end
         end
         s0 = s1 + 1;
      end

      // R4: four-zero code latency of five intervals, directed
      do_reset(1'b0, 1'b1);
      @(negedge clk);
      {rp, rn} = 2'b10;
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         {rp, rn} = 2'b00;
         check("R4 latency four-zero", {3'b000, nrz_o}, {3'b000, (k == 5)});
      end

      // R4: three-zero code latency of four intervals, directed
      do_reset(1'b0, 1'b0);
      @(negedge clk);
      {rp, rn} = 2'b01;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         {rp, rn} = 2'b00;
         check("R4 latency three-zero", {3'b000, nrz_o}, {3'b000, (k == 4)});
      end

      // R2/R3: pass-through with patterns that decode mode would flag
      bip_seq = '{2'b10, 2'b01, 2'b11, 2'b00, 2'b01, 2'b01,
                  2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10};
      do_reset(1'b1, 1'b0);
      prev = 2'b00;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         check("R2 rail echo", {2'b00, rail_pos_o, rail_neg_o}, {2'b00, prev});
         check("R3 decode quiet", {2'b00, nrz_o, cv_o}, 4'b0000);
         {rp, rn} = bip_seq[k];
         prev = bip_seq[k];
      end
      @(negedge clk);
      check("R2 rail echo last", {2'b00, rail_pos_o, rail_neg_o}, {2'b00, prev});
      check("R3 decode quiet last", {2'b00, nrz_o, cv_o}, 4'b0000);

      // R1: reset taken mid-stream clears everything
      do_reset(1'b1, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule